// File: doc/BRIEF.md
# Programmable RGB Raster Timing Generator

This block produces the raster timing for a parallel RGB panel clocked by a dot clock. It keeps a pixel counter and a line counter that walk the full raster. From them it drives horizontal sync, vertical sync, a data-enable strobe and a one-cycle frame-start pulse. Timing is described by total periods, sync widths and cumulative wait counts. A wait count is the distance from the start of the line or frame to the first active pixel or line, so it covers the sync pulse plus the back porch.

A host sets the configuration inputs and raises a run request. The configuration is captured only when the block leaves the stopped state, so changes made while it runs have no effect until the next start. When the run request falls, the block finishes the frame in progress and only then reports that it has stopped. A separate sync-enable input gates both sync outputs without stopping the counters. The block also keeps a frame-buffer base address for the pixel fetcher. A newly written address waits in a pending register and moves to the current-address output at the next frame start, which is where vertical sync begins. All pins are plain level or strobe signals. There is no streamed data path, so no valid/ready handshake is needed.

Top module: `rgb_raster_timer`

## Requirements
- R1: After reset `running` is 0, `pix_x`, `line_y`, `frame_start` and `cur_base` are 0, and `hsync`, `vsync` and `de` sit at 1, which is the inactive level for active-low signals.
- R2: When `run_req` is high while stopped, all configuration inputs are captured at that clock edge. The next cycle shows `running`=1, pixel 0, line 0 and `frame_start`=1. Configuration inputs changed while running have no effect until the next start.
- R3: `de` is at its active level on exactly `hvalid` pixels per line, starting at pixel `hwait`, on lines `vwait` to `vwait+vactive-1`. It is inactive on all other pixels and lines.
- R4: The pixel counter spans 0 to htot-1, where htot is `hline_word[17:0]`. The line counter spans 0 to `vtotal`-1.
- R5: While running, the pixel counter advances by one every clock. After the last pixel it returns to 0 and the line advances. After the last line the line counter returns to 0.
- R6: `hsync` is active for pixels below the horizontal sync width and `vsync` is active for lines below `vsync_w`. The horizontal sync width is `hline_word[31:18]` (14 bits) when `NARROW_HSW`=0, or `hline_word[31:24]` (8 bits) when `NARROW_HSW`=1. In `wait_word`, `hwait` is bits 27:16 and `vwait` is bits 15:0.
- R7: The `pol_sel` bits select polarity: bit 0 makes hsync active-high, bit 1 makes vsync active-high and bit 2 makes de active-high. A value of 0 in any of these bits means active-low. Bit 3 is captured like the other configuration and drives `dclk_fall`.
- R8: While `sync_on` is 0, `hsync` and `vsync` stay at their inactive level. The counters and `de` are unaffected.
- R9: A pulse on `next_base_we` captures `next_base`. `cur_base` takes the captured value in the cycle after a `frame_start` cycle and is otherwise unchanged.
- R10: When `run_req` is low during a frame, the block runs to the last pixel of the last line. In the following cycle `running` is 0 and the counters are 0. While stopped, the counters stay at 0 and `frame_start` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Run request level |
| sync_on | input | 1 | Enables sync outputs |
| hline_word | input | 32 | Line total [17:0] and horizontal sync width field |
| vtotal | input | 16 | Frame length in lines |
| vsync_w | input | 16 | Vertical sync width in lines |
| wait_word | input | 28 | hwait [27:16], vwait [15:0] |
| hvalid | input | 18 | Valid pixels per line |
| vactive | input | 16 | Active lines per frame |
| pol_sel | input | 4 | Polarity and dot-edge select bits |
| next_base | input | AW | Pending frame-buffer base address |
| next_base_we | input | 1 | Write strobe for next_base |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| dclk_fall | output | 1 | Captured falling-edge sampling select |
| pix_x | output | 18 | Pixel counter |
| line_y | output | 16 | Line counter |
| frame_start | output | 1 | High on pixel 0 of line 0 |
| cur_base | output | AW | Active frame-buffer base address |
| running | output | 1 | Run status |

## Verification
The bound checker watches four things on every cycle:
- the counters stay below the captured totals and step by one;
- the first data-enable pixel of each line lands on the captured horizontal wait count;
- the sync outputs rest inactive whenever the sync enable is low;
- `cur_base` moves only after a frame-start cycle, and `running` drops only after the final pixel of a frame.

Only the bench scenarios can show the following:
- the exact count of enabled pixels and lines in a whole frame;
- the sync pulse lengths and their polarity;
- that configuration changes during a run are ignored until the next start;
- the value a buffer swap delivers, and the reset levels.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int HCW    = 18;  // pixel counter / horizontal period width
  localparam int VCW    = 16;  // line counter / vertical period width
  localparam int HWAITW = 12;  // horizontal wait count width
  localparam int HSWW   = 14;  // widest horizontal sync width field

  typedef struct packed {
    logic [HCW-1:0]    htot;
    logic [HSWW-1:0]   hsw;
    logic [HWAITW-1:0] hwait;
    logic [HCW-1:0]    hvalid;
    logic [VCW-1:0]    vtot;
    logic [VCW-1:0]    vsw;
    logic [VCW-1:0]    vwait;
    logic [VCW-1:0]    vactive;
    logic              hs_hi;
    logic              vs_hi;
    logic              de_hi;
    logic              fall;
  } timing_t;
endpackage

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
  import rrt_pkg::*;
#(
  parameter bit NARROW_HSW = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_req,
  input  logic                 eof,
  input  logic [31:0]          hline_word,
  input  logic [VCW-1:0]       vtotal,
  input  logic [VCW-1:0]       vsync_w,
  input  logic [HWAITW+15:0]   wait_word,
  input  logic [HCW-1:0]       hvalid,
  input  logic [VCW-1:0]       vactive,
  input  logic [3:0]           pol_sel,
  output logic                 running,
  output timing_t              cfg
);
  logic [HSWW-1:0] hsw_field;
  timing_t         cfg_in;

  generate
    if (NARROW_HSW) begin : g_narrow
      assign hsw_field = {{(HSWW-8){1'b0}}, hline_word[31:24]};
    end else begin : g_wide
      assign hsw_field = hline_word[31:32-HSWW];
    end
  endgenerate

  always_comb begin
    cfg_in.htot    = hline_word[HCW-1:0];
    cfg_in.hsw     = hsw_field;
    cfg_in.hwait   = wait_word[HWAITW+15:16];
    cfg_in.hvalid  = hvalid;
    cfg_in.vtot    = vtotal;
    cfg_in.vsw     = vsync_w;
    cfg_in.vwait   = wait_word[15:0];
    cfg_in.vactive = vactive;
    cfg_in.hs_hi   = pol_sel[0];
    cfg_in.vs_hi   = pol_sel[1];
    cfg_in.de_hi   = pol_sel[2];
    cfg_in.fall    = pol_sel[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cfg     <= '0;
    end else if (!running && run_req) begin
      running <= 1'b1;
      cfg     <= cfg_in;
    end else if (running && eof && !run_req) begin
      running <= 1'b0;
    end
  end
endmodule

// File: rtl/rrt_counter.sv
module rrt_counter
  import rrt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           running,
  input  logic [HCW-1:0] htot,
  input  logic [VCW-1:0] vtot,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           eof
);
  logic h_last, v_last;

  assign h_last = (hcnt == htot - HCW'(1));
  assign v_last = (vcnt == vtot - VCW'(1));
  assign eof    = running && h_last && v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!running) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + VCW'(1);
    end else begin
      hcnt <= hcnt + HCW'(1);
    end
  end
endmodule

// File: rtl/rrt_decode.sv
module rrt_decode
  import rrt_pkg::*;
(
  input  logic              running,
  input  logic              sync_on,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  input  logic [HSWW-1:0]   hsw,
  input  logic [HWAITW-1:0] hwait,
  input  logic [HCW-1:0]    hvalid,
  input  logic [VCW-1:0]    vsw,
  input  logic [VCW-1:0]    vwait,
  input  logic [VCW-1:0]    vactive,
  input  logic              hs_hi,
  input  logic              vs_hi,
  input  logic              de_hi,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              frame_start
);
  logic [HCW-1:0] hwait_x;
  logic [HCW:0]   h_end;
  logic [VCW:0]   v_end;
  logic           h_sync_zone, v_sync_zone, h_win, v_win;

  assign hwait_x     = {{(HCW-HWAITW){1'b0}}, hwait};
  assign h_end       = {1'b0, hwait_x} + {1'b0, hvalid};
  assign v_end       = {1'b0, vwait} + {1'b0, vactive};
  assign h_sync_zone = hcnt < {{(HCW-HSWW){1'b0}}, hsw};
  assign v_sync_zone = vcnt < vsw;
  assign h_win       = (hcnt >= hwait_x) && ({1'b0, hcnt} < h_end);
  assign v_win       = (vcnt >= vwait) && ({1'b0, vcnt} < v_end);

  assign hsync       = (running && sync_on && h_sync_zone) ? hs_hi : ~hs_hi;
  assign vsync       = (running && sync_on && v_sync_zone) ? vs_hi : ~vs_hi;
  assign de          = (running && h_win && v_win) ? de_hi : ~de_hi;
  assign frame_start = running && (hcnt == '0) && (vcnt == '0);
endmodule

// File: rtl/rrt_bufswap.sv
module rrt_bufswap #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] next_base,
  input  logic          next_base_we,
  input  logic          frame_start,
  output logic [AW-1:0] cur_base
);
  logic [AW-1:0] pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      cur_base  <= '0;
    end else begin
      if (next_base_we) pending_q <= next_base;
      if (frame_start)  cur_base  <= pending_q;
    end
  end
endmodule

// File: rtl/rgb_raster_timer.sv
module rgb_raster_timer
  import rrt_pkg::*;
#(
  parameter int AW         = 32,
  parameter bit NARROW_HSW = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_req,
  input  logic                 sync_on,
  input  logic [31:0]          hline_word,
  input  logic [15:0]          vtotal,
  input  logic [15:0]          vsync_w,
  input  logic [27:0]          wait_word,
  input  logic [17:0]          hvalid,
  input  logic [15:0]          vactive,
  input  logic [3:0]           pol_sel,
  input  logic [AW-1:0]        next_base,
  input  logic                 next_base_we,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic                 dclk_fall,
  output logic [17:0]          pix_x,
  output logic [15:0]          line_y,
  output logic                 frame_start,
  output logic [AW-1:0]        cur_base,
  output logic                 running
);
  timing_t cfg_q;
  logic    eof;

  rrt_ctrl #(.NARROW_HSW(NARROW_HSW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .eof(eof),
    .hline_word(hline_word), .vtotal(vtotal), .vsync_w(vsync_w),
    .wait_word(wait_word), .hvalid(hvalid), .vactive(vactive),
    .pol_sel(pol_sel), .running(running), .cfg(cfg_q)
  );

  rrt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .running(running),
    .htot(cfg_q.htot), .vtot(cfg_q.vtot),
    .hcnt(pix_x), .vcnt(line_y), .eof(eof)
  );

  rrt_decode u_dec (
    .running(running), .sync_on(sync_on), .hcnt(pix_x), .vcnt(line_y),
    .hsw(cfg_q.hsw), .hwait(cfg_q.hwait), .hvalid(cfg_q.hvalid),
    .vsw(cfg_q.vsw), .vwait(cfg_q.vwait), .vactive(cfg_q.vactive),
    .hs_hi(cfg_q.hs_hi), .vs_hi(cfg_q.vs_hi), .de_hi(cfg_q.de_hi),
    .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start)
  );

  rrt_bufswap #(.AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .next_base(next_base),
    .next_base_we(next_base_we), .frame_start(frame_start),
    .cur_base(cur_base)
  );

  assign dclk_fall = cfg_q.fall;
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          sync_on,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [17:0]   pix_x,
  input logic [15:0]   line_y,
  input logic          frame_start,
  input logic [AW-1:0] cur_base,
  input logic [17:0]   c_htot,
  input logic [15:0]   c_vtot,
  input logic [11:0]   c_hwait,
  input logic          c_hs_hi,
  input logic          c_vs_hi,
  input logic          c_de_hi
);
  logic de_act;
  assign de_act = running && (de == c_de_hi);

  a_r4_pix_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> pix_x < c_htot);

  a_r4_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> line_y < c_vtot);

  a_r5_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && ($past(pix_x) + 18'd1 != c_htot))
      |-> pix_x == $past(pix_x) + 18'd1);

  a_r3_de_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_act) |-> pix_x == {6'b0, c_hwait});

  a_r8_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |-> (hsync != c_hs_hi) && (vsync != c_vs_hi));

  a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(cur_base));

  a_r10_stop_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(pix_x) + 18'd1 == c_htot) && ($past(line_y) + 16'd1 == c_vtot));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pix_x == '0) && (line_y == '0) && !frame_start);
endmodule

bind rgb_raster_timer rrt_checker #(.AW(AW)) u_rrt_checker (
  .clk(clk), .rst_n(rst_n), .running(running), .sync_on(sync_on),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .line_y(line_y),
  .frame_start(frame_start), .cur_base(cur_base),
  .c_htot(cfg_q.htot), .c_vtot(cfg_q.vtot), .c_hwait(cfg_q.hwait),
  .c_hs_hi(cfg_q.hs_hi), .c_vs_hi(cfg_q.vs_hi), .c_de_hi(cfg_q.de_hi)
);

// File: tb/test_rgb_raster_timer.sv
module test_rgb_raster_timer;
  localparam int AW = 32;
  localparam int HT = 12, HSW = 2, HWAIT = 4, VT = 8, VSW = 1, VWAIT = 3, VACT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_req = 1'b0, sync_on = 1'b1, next_base_we = 1'b0;
  logic [31:0] hline_word = '0;
  logic [15:0] vtotal = '0, vsync_w = '0, vactive = '0;
  logic [27:0] wait_word = '0;
  logic [17:0] hvalid = '0;
  logic [3:0]  pol_sel = '0;
  logic [AW-1:0] next_base = '0;
  logic hsync, vsync, de, dclk_fall, frame_start, running;
  logic [17:0] pix_x;
  logic [15:0] line_y;
  logic [AW-1:0] cur_base;

  int n_chk = 0, n_fail = 0;
  int e_hvalid = 5;
  logic [3:0] e_pol = '0;
  bit done = 1'b0;

  rgb_raster_timer #(.AW(AW)) i_rgb_raster_timer (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .sync_on(sync_on),
    .hline_word(hline_word), .vtotal(vtotal), .vsync_w(vsync_w),
    .wait_word(wait_word), .hvalid(hvalid), .vactive(vactive),
    .pol_sel(pol_sel), .next_base(next_base), .next_base_we(next_base_we),
    .hsync(hsync), .vsync(vsync), .de(de), .dclk_fall(dclk_fall),
    .pix_x(pix_x), .line_y(line_y), .frame_start(frame_start),
    .cur_base(cur_base), .running(running)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_cfg(input int hv, input logic [3:0] pol);
    hline_word = (32'(HSW) << 18) | 32'(HT);
    vtotal     = 16'(VT);
    vsync_w    = 16'(VSW);
    wait_word  = (28'(HWAIT) << 16) | 28'(VWAIT);
    hvalid     = 18'(hv);
    vactive    = 16'(VACT);
    pol_sel    = pol;
  endtask

  // Walks one frame; the next negedge must be pixel 0 of line 0.
  task automatic walk_frame(input string sync_tag, input bit e_sync);
    int m_pos = 0, m_fs = 0, m_h = 0, m_v = 0, m_de = 0, m_run = 0, de_cnt = 0;
    for (int k = 0; k < HT*VT; k++) begin
      int h, v;
      logic eh, ev, ed;
      @(negedge clk);
      h = k % HT; v = k / HT;
      eh = (e_sync && h < HSW) ? e_pol[0] : ~e_pol[0];
      ev = (e_sync && v < VSW) ? e_pol[1] : ~e_pol[1];
      ed = (h >= HWAIT && h < HWAIT + e_hvalid && v >= VWAIT && v < VWAIT + VACT) ? e_pol[2] : ~e_pol[2];
      if (pix_x !== 18'(h) || line_y !== 16'(v)) m_pos++;
      if (frame_start !== (k == 0)) m_fs++;
      if (hsync !== eh) m_h++;
      if (vsync !== ev) m_v++;
      if (de !== ed) m_de++;
      if (de === e_pol[2]) de_cnt++;
      if (running !== 1'b1) m_run++;
    end
    chk(m_pos == 0, "R5 counter sequence mismatches", m_pos, 0);
    chk(m_fs == 0, "R2 frame_start mismatches", m_fs, 0);
    chk(m_h == 0, {sync_tag, " hsync mismatches"}, m_h, 0);
    chk(m_v == 0, {sync_tag, " vsync mismatches"}, m_v, 0);
    chk(m_de == 0, "R3 de mismatches", m_de, 0);
    chk(de_cnt == e_hvalid*VACT, "R3 de active count", de_cnt, e_hvalid*VACT);
    chk(m_run == 0, "R4 running during frame", m_run, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(running == 1'b0, "R1 running", running, 0);
    chk(pix_x == 0 && line_y == 0, "R1 counters", pix_x, 0);
    chk(frame_start == 1'b0, "R1 frame_start", frame_start, 0);
    chk(cur_base == 0, "R1 cur_base", cur_base, 0);
    chk({hsync, vsync, de} == 3'b111, "R1 idle levels", {hsync, vsync, de}, 7);
  endtask

  task automatic t_start();
    drive_cfg(5, 4'b0000);
    e_hvalid = 5; e_pol = 4'b0000;
    run_req = 1'b1;
    walk_frame("R6", 1'b1);
  endtask

  task automatic t_change_ignored();
    drive_cfg(3, 4'b1111);   // not captured while running
    walk_frame("R2", 1'b1);
    chk(dclk_fall == 1'b0, "R2 dclk_fall unchanged", dclk_fall, 0);
    drive_cfg(5, 4'b0000);
  endtask

  task automatic t_sync_off();
    sync_on = 1'b0;
    walk_frame("R8", 1'b0);
    sync_on = 1'b1;
  endtask

  task automatic t_swap();
    for (int k = 0; k < HT*VT; k++) begin
      @(negedge clk);
      if (k == 10) begin next_base = 32'hABC0; next_base_we = 1'b1; end
      else next_base_we = 1'b0;
      if (k == HT*VT-1) chk(cur_base == 0, "R9 base held until frame start", cur_base, 0);
    end
    @(negedge clk);
    chk(frame_start == 1'b1, "R9 frame_start at swap", frame_start, 1);
    chk(cur_base == 0, "R9 base old on frame_start cycle", cur_base, 0);
    @(negedge clk);
    chk(cur_base == 32'hABC0, "R9 base swapped", cur_base, 32'hABC0);
    for (int k = 2; k < HT*VT; k++) @(negedge clk);
  endtask

  task automatic t_stop();
    int early = 0;
    for (int k = 0; k < HT*VT; k++) begin
      @(negedge clk);
      if (k == 5) run_req = 1'b0;
      if (running !== 1'b1) early++;
    end
    chk(early == 0, "R10 runs to end of frame", early, 0);
    @(negedge clk);
    chk(running == 1'b0, "R10 stopped after last pixel", running, 0);
    chk(pix_x == 0 && line_y == 0, "R10 counters zero", pix_x, 0);
    chk(frame_start == 1'b0, "R10 no frame_start while stopped", frame_start, 0);
    repeat (3) @(negedge clk);
    chk(running == 1'b0 && pix_x == 0, "R10 stays stopped", running, 0);
  endtask

  task automatic t_restart_new_cfg();
    drive_cfg(3, 4'b1111);
    e_hvalid = 3; e_pol = 4'b1111;
    run_req = 1'b1;
    walk_frame("R7", 1'b1);
    chk(dclk_fall == 1'b1, "R7 dclk_fall captured", dclk_fall, 1);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start();
    t_change_ignored();
    t_sync_off();
    t_swap();
    t_stop();
    t_restart_new_cfg();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule